// File: doc/BRIEF.md
# Coupling-Aware Odd/Full Inversion Link Codec

This block sits at the two ends of an on-chip point-to-point link and recodes each data word so that adjacent wires switch against each other less often. Before a word goes out, the encoder compares it with the word most recently driven onto the link and classifies every pair of neighbouring wires. Three kinds of pair are counted: pairs where exactly one wire would toggle, pairs where both wires would toggle in opposite directions, and pairs where neither wire would toggle but the two wires hold different values. From these three counts the encoder picks one of three modes: send the word as it is, invert its odd-indexed wires, or invert every wire.

A single flag wire carries the choice. The flag reads 0 when the word is sent unchanged and 1 after either inversion. The receiving side works out which inversion was used without any extra wire. It counts the single-toggle pairs between the received word and the word received before it. Odd inversion swaps single-toggle pairs with the other kinds of pair, while full inversion leaves that count as it is. This makes the majority of that count enough to name the mode. To keep this recovery exact, the encoder only inverts when single-toggle pairs are in the majority.

The encoder output and the decoded data are both registered. In a loopback setup the decoded payload appears two clock cycles after it was offered.

Top module: `oddfull_link_codec`

## Requirements
- R1: While reset is low at a clock edge, the link word, link valid, decoded valid and decoded data all become zero. The history words on both sides also become zero, so the first word after reset is compared against all-zero lines.
- R2: The link word has W lines, with W even. Lines W-2..0 carry the payload and line W-1 is the flag. In plain mode the flag is 0 and the payload lines equal the offered data bit for bit.
- R3: Each pair of adjacent lines (i, i+1), for i from 0 to W-2, is classified using the candidate word {0, payload} and the previous link word. "Single" means exactly one of the two lines changes. "Opposite" means both lines change and their new values differ. "Static-differ" means neither line changes and the two values differ. Each class is counted separately.
- R4: Odd inversion is chosen when Single > (W-1)/2 and 2·(Opposite − StaticDiff) < 2·Single − W + 1. It XORs the candidate with a mask that is 1 on every odd line index (1, 3, …, W-1), so the flag line ends at 1.
- R5: Full inversion is chosen when Single > (W-1)/2, Opposite > StaticDiff and 2·(Opposite − StaticDiff) > 2·Single − W + 1. All W lines of the candidate are inverted. Odd inversion wins if both rules hold.
- R6: When Single ≤ (W-1)/2, the word is sent plain with flag 0, however many opposite pairs it has.
- R7: A word offered with tx_valid at a clock edge appears on link_word with link_valid high after that edge. Without tx_valid, link_valid is low after the edge, link_word holds its value, and the history used for the next decision does not change.
- R8: The decoder registers a result one edge after rx_valid. With flag 0 it passes the payload lines through. With flag 1 it counts single-toggle pairs between the received word and the previous received word: a count of at least W/2 undoes full inversion, and a smaller count undoes odd inversion. Its history advances only on rx_valid.
- R9: With the link looped back, every offered payload comes out of the decoder unchanged two edges later. This holds for random and correlated streams, with or without idle gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_valid | input | 1 | Payload offered for transmission this cycle |
| tx_data | input | W-1 | Payload to encode |
| link_valid | output | 1 | Link word carries a new flit |
| link_word | output | W | Encoded link lines, flag on line W-1 |
| rx_valid | input | 1 | Received link word is new this cycle |
| rx_word | input | W | Received link lines |
| dec_valid | output | 1 | Decoded payload is new |
| dec_data | output | W-1 | Recovered payload |

## Verification
The bench builds the codec with W = 8, so the link has seven wire pairs and a 7-bit payload. With only seven pairs, a single hand-chosen word can hit each decision exactly. The bench uses words that land on odd inversion, on full inversion, and on a plain send in which opposite toggles dominate but the single-toggle count is below the majority. Random and incrementing packets then cover many pair patterns and idle gaps. The bench also prints the weighted coupling cost of the coded stream next to the cost the same stream would have had unencoded.

// File: rtl/link_inv_pkg.sv
// Shared definitions for the odd/full inversion link codec.
// Assumes nothing beyond IEEE 1800-2017 packages.
package link_inv_pkg;

    // Encoding applied to a link word; bit 1 doubles as "flag set"
    typedef enum logic [1:0] {
        INV_NONE = 2'b00,
        INV_ODD  = 2'b10,
        INV_FULL = 2'b11
    } inv_mode_e;

    // Pair classes detected between a candidate word and the last sent word
    localparam int FAM_SINGLE   = 0;   // exactly one wire of the pair toggles
    localparam int FAM_OPPOSITE = 1;   // both toggle, ending on different values
    localparam int FAM_STATIC   = 2;   // neither toggles, values differ
    localparam int NUM_FAM      = 3;

endpackage

// File: rtl/pair_classifier.sv
// Flags, for every pair of adjacent lines, whether the pair belongs to the
// class selected by FAMILY when moving from prv to cur.
// Assumes W >= 2; output bit i covers lines i and i+1.
module pair_classifier
    import link_inv_pkg::*;
#(
    parameter int W      = 32,
    parameter int FAMILY = FAM_SINGLE
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prv,
    output logic [W-2:0] hit
);

    for (genvar i = 0; i < W - 1; i++) begin : g_pair
        logic lo_tog;
        logic hi_tog;
        logic differ;

        // per-pair toggle and value-difference terms
        assign lo_tog = cur[i]     ^ prv[i];
        assign hi_tog = cur[i + 1] ^ prv[i + 1];
        assign differ = cur[i]     ^ cur[i + 1];

        if (FAMILY == FAM_SINGLE) begin : g_single
            assign hit[i] = lo_tog ^ hi_tog;
        end else if (FAMILY == FAM_OPPOSITE) begin : g_opp
            assign hit[i] = lo_tog & hi_tog & differ;
        end else begin : g_static
            assign hit[i] = ~lo_tog & ~hi_tog & differ;
        end
    end

endmodule

// File: rtl/ones_counter.sv
// Counts the set bits of a vector.
// Assumes CW is wide enough to hold N.
module ones_counter #(
    parameter int N  = 31,
    parameter int CW = 5
) (
    input  logic [N-1:0]  bits,
    output logic [CW-1:0] count
);

    // ripple population count, reduced to an adder tree by synthesis
    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + CW'(bits[i]);
        end
    end

endmodule

// File: rtl/inv_decider.sv
// Chooses plain, odd or full inversion from the three pair counts.
// Assumes W is even, so 2*Single - (W-1) is odd and the two inequalities
// can never meet at equality; odd inversion still has priority.
module inv_decider
    import link_inv_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = 5
) (
    input  logic [CW-1:0] single_cnt,
    input  logic [CW-1:0] opp_cnt,
    input  logic [CW-1:0] static_cnt,
    output inv_mode_e     mode
);

    localparam int SW = CW + 3;
    localparam logic signed [SW-1:0] PAIRS_S   = SW'(W - 1);
    localparam logic        [CW-1:0] HALF_PAIR = CW'((W - 1) / 2);

    logic signed [SW-1:0] single_s;
    logic signed [SW-1:0] opp_s;
    logic signed [SW-1:0] static_s;
    logic signed [SW-1:0] full_gain;
    logic signed [SW-1:0] odd_gain;
    logic                 majority;

    // sign-extend counts and form both sides of the comparison
    always_comb begin
        single_s  = $signed({3'b000, single_cnt});
        opp_s     = $signed({3'b000, opp_cnt});
        static_s  = $signed({3'b000, static_cnt});
        full_gain = (opp_s - static_s) <<< 1;
        odd_gain  = (single_s <<< 1) - PAIRS_S;
        majority  = single_cnt > HALF_PAIR;
    end

    // pick the mode; odd first, full only under the same majority
    always_comb begin
        mode = INV_NONE;
        if (majority) begin
            if (full_gain < odd_gain) begin
                mode = INV_ODD;
            end else if ((opp_cnt > static_cnt) && (full_gain > odd_gain)) begin
                mode = INV_FULL;
            end
        end
    end

endmodule

// File: rtl/oddfull_link_codec.sv
// Transmit-side encoder and receive-side decoder of a W-line link that uses
// one flag line for two inversion modes. The encoder registers its output;
// the decoder registers its result one edge after rx_valid.
// Assumes W is even so that the flag line W-1 is an odd-indexed line.
module oddfull_link_codec
    import link_inv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_valid,
    input  logic [W-2:0] tx_data,
    output logic         link_valid,
    output logic [W-1:0] link_word,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_word,
    output logic         dec_valid,
    output logic [W-2:0] dec_data
);

    localparam int CW = $clog2(W);

    function automatic logic [W-1:0] odd_line_mask();
        logic [W-1:0] m;
        for (int i = 0; i < W; i++) begin
            m[i] = (i % 2) == 1;
        end
        return m;
    endfunction

    localparam logic [W-1:0] ODD_MASK = odd_line_mask();

    // ---------------- encoder ----------------
    logic [W-1:0]  cand;
    logic [W-2:0]  fam_hit [NUM_FAM];
    logic [CW-1:0] fam_cnt [NUM_FAM];
    inv_mode_e     mode;
    logic [W-1:0]  enc_word;

    assign cand = {1'b0, tx_data};

    for (genvar f = 0; f < NUM_FAM; f++) begin : g_fam
        pair_classifier #(.W(W), .FAMILY(f)) u_cls (
            .cur (cand),
            .prv (link_word),
            .hit (fam_hit[f])
        );
        ones_counter #(.N(W - 1), .CW(CW)) u_cnt (
            .bits  (fam_hit[f]),
            .count (fam_cnt[f])
        );
    end

    inv_decider #(.W(W), .CW(CW)) u_dec (
        .single_cnt (fam_cnt[FAM_SINGLE]),
        .opp_cnt    (fam_cnt[FAM_OPPOSITE]),
        .static_cnt (fam_cnt[FAM_STATIC]),
        .mode       (mode)
    );

    // apply the chosen inversion to the candidate word
    always_comb begin
        case (mode)
            INV_ODD:  enc_word = cand ^ ODD_MASK;
            INV_FULL: enc_word = ~cand;
            default:  enc_word = cand;
        endcase
    end

    // drive the link; the held word is also the encoder's history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_valid <= 1'b0;
            link_word  <= '0;
        end else begin
            link_valid <= tx_valid;
            if (tx_valid) begin
                link_word <= enc_word;
            end
        end
    end

    // ---------------- decoder ----------------
    logic [W-1:0]  rx_prev;
    logic [W-2:0]  rx_single;
    logic [CW-1:0] rx_cnt;
    logic          rx_major;
    logic [W-2:0]  undo_mask;

    pair_classifier #(.W(W), .FAMILY(FAM_SINGLE)) u_rx_cls (
        .cur (rx_word),
        .prv (rx_prev),
        .hit (rx_single)
    );

    ones_counter #(.N(W - 1), .CW(CW)) u_rx_cnt (
        .bits  (rx_single),
        .count (rx_cnt)
    );

    // rebuild the mask the encoder used from flag and single-pair majority
    always_comb begin
        rx_major = rx_cnt >= CW'(W / 2);
        if (!rx_word[W-1]) begin
            undo_mask = '0;
        end else if (rx_major) begin
            undo_mask = '1;
        end else begin
            undo_mask = ODD_MASK[W-2:0];
        end
    end

    // register decoded payload and advance receive history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_data  <= '0;
            rx_prev   <= '0;
        end else begin
            dec_valid <= rx_valid;
            if (rx_valid) begin
                dec_data <= rx_word[W-2:0] ^ undo_mask;
                rx_prev  <= rx_word;
            end
        end
    end

endmodule

// File: rtl/oddfull_link_codec_chk.sv
// Port-level properties of the odd/full inversion link codec.
// Assumes it is bound to every instance of oddfull_link_codec.
module oddfull_link_codec_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tx_valid,
    input logic [W-2:0] tx_data,
    input logic         link_valid,
    input logic [W-1:0] link_word,
    input logic         rx_valid,
    input logic [W-1:0] rx_word,
    input logic         dec_valid,
    input logic [W-2:0] dec_data
);

    function automatic logic [W-2:0] odd_payload_mask();
        logic [W-2:0] m;
        for (int i = 0; i < W - 1; i++) begin
            m[i] = (i % 2) == 1;
        end
        return m;
    endfunction

    localparam logic [W-2:0] ODD_PAY = odd_payload_mask();

    // R1: a reset edge clears every output
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (link_word == '0 && !link_valid && !dec_valid && dec_data == '0));

    // R7: link valid tracks tx_valid by one edge
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> link_valid);

    // R7: idle cycles hold the link word
    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |=> (!link_valid && $stable(link_word)));

    // R2: flag low means the payload went out verbatim
    a_r2_plain_verbatim: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid ##1 !link_word[W-1]) |-> link_word[W-2:0] == $past(tx_data));

    // R4: a set flag means an odd or a full inversion of the payload
    a_r4_inverted_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid ##1 link_word[W-1]) |->
            (link_word[W-2:0] == ($past(tx_data) ^ ODD_PAY) ||
             link_word[W-2:0] == ~$past(tx_data)));

    // R8: decoder valid follows rx_valid by one edge
    a_r8_dec_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> dec_valid);

    // R8: unflagged words pass the decoder unchanged
    a_r8_dec_plain_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_word[W-1]) |=> dec_data == $past(rx_word[W-2:0]));

endmodule

bind oddfull_link_codec oddfull_link_codec_chk #(.W(W)) u_chk (.*);

// File: tb/test_oddfull_link_codec.sv
`timescale 1ns/1ps
// Directed bench for the odd/full inversion codec, W = 8, link looped back.
module test_oddfull_link_codec;

    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tx_valid = 1'b0;
    logic [LW-2:0] tx_data = '0;
    logic          link_valid;
    logic [LW-1:0] link_word;
    logic          dec_valid;
    logic [LW-2:0] dec_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [LW-1:0] m_prev = '0;
    logic          pend_v = 1'b0;
    logic [LW-2:0] pend_p = '0;
    int cost_coded = 0;
    int cost_raw   = 0;
    logic [LW-1:0] raw_prev = '0;
    int n_plain = 0;
    int n_odd   = 0;
    int n_full  = 0;

    always #2.5 clk = ~clk;

    oddfull_link_codec #(.W(LW)) i_oddfull_link_codec (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .link_valid (link_valid),
        .link_word  (link_word),
        .rx_valid   (link_valid),
        .rx_word    (link_word),
        .dec_valid  (dec_valid),
        .dec_data   (dec_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // pair classes and decision per R3..R6
    function automatic logic [LW-1:0] m_encode(input logic [LW-1:0] prev, input logic [LW-2:0] pay);
        logic [LW-1:0] c;
        logic [LW-1:0] d;
        int sgl;
        int opp;
        int sta;
        c = {1'b0, pay};
        d = c ^ prev;
        sgl = 0; opp = 0; sta = 0;
        for (int i = 0; i < LW - 1; i++) begin
            if (d[i] != d[i+1]) sgl++;
            else if (d[i] && c[i] != c[i+1]) opp++;
            else if (!d[i] && c[i] != c[i+1]) sta++;
        end
        if (2 * sgl > LW - 1) begin
            if (2 * (opp - sta) < 2 * sgl - (LW - 1)) return c ^ 8'hAA;
            if (opp > sta && 2 * (opp - sta) > 2 * sgl - (LW - 1)) return ~c;
        end
        return c;
    endfunction

    // weighted coupling cost: 1 per single toggle pair, 2 per opposite pair
    function automatic int pair_cost(input logic [LW-1:0] prev, input logic [LW-1:0] cur);
        logic [LW-1:0] d;
        int s;
        d = prev ^ cur;
        s = 0;
        for (int i = 0; i < LW - 1; i++) begin
            if (d[i] != d[i+1]) s += 1;
            else if (d[i] && cur[i] != cur[i+1]) s += 2;
        end
        return s;
    endfunction

    // one cycle: drive at negedge, check link and decoder at next negedge
    task automatic push(input logic v, input logic [LW-2:0] p);
        logic [LW-1:0] exp;
        string tag;
        exp = m_prev;
        tx_valid = v;
        tx_data  = p;
        if (v) exp = m_encode(m_prev, p);
        @(negedge clk);
        if (v) begin
            if (!exp[LW-1]) begin tag = "R6/R2 plain"; n_plain++; end
            else if (exp == ~{1'b0, p}) begin tag = "R5 full"; n_full++; end
            else begin tag = "R4 odd"; n_odd++; end
            chk(link_valid && link_word == exp, tag, {23'd0, link_valid, link_word}, {24'd1, exp});
            cost_coded += pair_cost(m_prev, exp);
            cost_raw   += pair_cost(raw_prev, {1'b0, p});
            raw_prev = {1'b0, p};
            m_prev = exp;
        end else begin
            chk(!link_valid && link_word == m_prev, "R7 idle hold", {23'd0, link_valid, link_word}, {24'd0, m_prev});
        end
        if (pend_v) chk(dec_valid && dec_data == pend_p, "R9 round trip", {24'd0, dec_valid, dec_data}, {24'd1, 1'b1, pend_p});
        else chk(!dec_valid, "R8 dec valid idle", {31'd0, dec_valid}, 32'd0);
        pend_v = v;
        pend_p = p;
    endtask

    task automatic do_reset();
        tx_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(link_word == '0 && !link_valid && !dec_valid && dec_data == '0, "R1 reset state",
            {15'd0, link_valid, link_word, dec_valid, dec_data}, 32'd0);
        rst_n = 1'b1;
        m_prev = '0;
        raw_prev = '0;
        pend_v = 1'b0;
    endtask

    // R3/R4/R5/R6 with hand-worked words from an all-zero history
    task automatic t_directed();
        push(1'b1, 7'b0000000);
        chk(link_word == 8'h00, "R6 zero word plain", {24'd0, link_word}, 32'h00);
        push(1'b1, 7'b0101010);
        chk(link_word == 8'h80, "R4 R3 odd pick", {24'd0, link_word}, 32'h80);
        push(1'b1, 7'b1101001);
        chk(link_word == 8'h96, "R5 R3 full pick", {24'd0, link_word}, 32'h96);
        push(1'b1, 7'b1101001);
        chk(link_word == 8'h69, "R6 no majority plain", {24'd0, link_word}, 32'h69);
        push(1'b0, 7'b1111111);
        push(1'b0, 7'b0000000);
        chk(dec_data == 7'b1101001, "R8 decoder holds", {25'd0, dec_data}, {25'd0, 7'b1101001});
    endtask

    task automatic t_random();
        for (int pk = 0; pk < 40; pk++) begin
            for (int f = 0; f < 8; f++) push(1'b1, 7'($urandom));
            push(1'b0, 7'($urandom));
        end
    endtask

    task automatic t_correlated();
        logic [LW-2:0] v;
        v = 7'h11;
        for (int pk = 0; pk < 20; pk++) begin
            for (int f = 0; f < 8; f++) begin
                push(1'b1, v);
                v = (pk % 2 == 0) ? v + 7'd1 : {v[5:0], v[6]};
            end
            push(1'b0, v);
        end
    endtask

    // R1: reset mid-stream clears history; same word re-encodes as from zero
    task automatic t_reset_mid();
        push(1'b1, 7'b0110011);
        push(1'b1, 7'b1001100);
        do_reset();
        @(negedge clk);
        push(1'b1, 7'b0101010);
        chk(link_word == 8'h80, "R1 history cleared", {24'd0, link_word}, 32'h80);
        push(1'b0, 7'b0);
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        t_directed();
        t_random();
        t_correlated();
        t_reset_mid();
        $display("coupling cost coded=%0d raw=%0d (plain=%0d odd=%0d full=%0d)",
                 cost_coded, cost_raw, n_plain, n_odd, n_full);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule